// File: doc/BRIEF.md
# Frame Processing Start/Stop Controller

This block decides when a frame-processing period begins and ends. The host arms it with a GO bit while an external START level is high. The event that opens a period depends on the direction of transfer. In compression it is a rising edge of the vertical input enable. In expansion it is the first data-sync strobe from the codec side. A period then lasts until an end-of-frame indication arrives, and a frame-busy output stays high for the whole of it.

In single-frame mode the controller handles one frame, asks the register file to clear GO, and stays idle until GO is written again. In sequential mode GO stays set, and the controller re-arms by itself so that each frame opens a new period while START stays high. The block also applies the hard-reset rules. A reset must be held for a minimum number of cycles, and the internal state stays in reset for a few extra cycles after reset is released.

Top module: `frame_ctrl`

## Requirements
- R1: While `rst` is sampled high, `fbusy` and `go_clr` are 0 from the next clock edge on.
- R2: For STRETCH (default 2) clock edges after `rst` is first sampled low, all other inputs are ignored. The earliest edge that can arm the controller is the (STRETCH+1)-th edge after release.
- R3: The controller arms only on an edge where `go`=1 and `start`=1. If either input is sampled 0 while armed, the controller returns to idle and no period starts.
- R4: With `comp`=1 (compression), an armed controller starts a period on an edge where `vsync_in` is 1 and was 0 at the previous edge. `dsync` has no effect in this mode.
- R5: With `comp`=0 (expansion), an armed controller starts a period on the first edge where `dsync` is 1. `vsync_in` has no effect in this mode.
- R6: `fbusy` rises after the start edge and stays 1 until the edge on which `eof`=1 is sampled. Clearing `go` during a period does not end it.
- R7: With `seq`=0 (single frame), `go_clr` is 1 for exactly one cycle, in the cycle in which `fbusy` has just fallen. No further period starts until `go` is set again.
- R8: With `seq`=1 (sequential), `go_clr` stays 0. While `go` and `start` stay 1, the controller re-arms two edges after a period ends and starts the next period at the next start event.
- R9: In compression, a `vsync_in` level that stays high from the previous period does not start a new one. A fresh 0-to-1 transition is required after re-arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hard reset, active high |
| go | input | 1 | Host GO bit from the register file |
| start | input | 1 | External start level |
| comp | input | 1 | 1 = compression, 0 = expansion |
| seq | input | 1 | 1 = sequential mode, 0 = single-frame mode |
| vsync_in | input | 1 | Vertical input data enable |
| dsync | input | 1 | Data-sync strobe from the codec side |
| eof | input | 1 | End-of-frame indication, one cycle |
| fbusy | output | 1 | High throughout a processing period |
| go_clr | output | 1 | One-cycle request to clear GO (single-frame mode) |

## Verification
The assertions assume three things about the inputs. Reset is held for at least MIN_RST edges. `comp` and `seq` do not change during a period. `eof` arrives only while a period is open. The stimulus holds reset for ten edges and sets the mode bits only while the controller is idle. It raises `eof` only after `fbusy` has been seen high. The sweep covers every combination of direction and frame mode. In each combination it tries the start event of the other direction, a held vertical level, dropping START and clearing GO while armed, and clearing GO during a period.

// File: rtl/frame_ctrl_pkg.sv
package frame_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_BUSY  = 2'd2,
    ST_DONE  = 2'd3
  } fc_state_e;
endpackage

// File: rtl/fc_rst_stretch.sv
module fc_rst_stretch #(
  parameter int MIN_RST = 8,
  parameter int STRETCH = 2
) (
  input  logic clk,
  input  logic rst,
  output logic irst
);
  localparam int CW = $clog2(STRETCH + 1);
  localparam int LW = $clog2(MIN_RST + 1);

  logic [CW-1:0] hold_cnt = '0;
  logic [LW-1:0] len_cnt  = '0;

  // Extra internal-reset cycles after the input is released
  always_ff @(posedge clk) begin
    if (rst)
      hold_cnt <= CW'(STRETCH);
    else if (hold_cnt != '0)
      hold_cnt <= hold_cnt - CW'(1);
  end

  // Saturating count of consecutive reset cycles
  always_ff @(posedge clk) begin
    if (!rst)
      len_cnt <= '0;
    else if (len_cnt != LW'(MIN_RST))
      len_cnt <= len_cnt + LW'(1);
  end

  assign irst = rst || (hold_cnt != '0);

  // Input assumption: reset pulse long enough
  p_rst_len_r2: assert property (@(posedge clk)
    $fell(rst) |-> (len_cnt == LW'(MIN_RST)));
  // R2: internal reset stays asserted right after the release
  p_hold_after_release_r2: assert property (@(posedge clk)
    $fell(rst) |-> irst);
endmodule

// File: rtl/fc_event_sel.sv
module fc_event_sel (
  input  logic clk,
  input  logic comp,
  input  logic vsync_in,
  input  logic dsync,
  output logic evt
);
  logic vs_q = 1'b1;

  always_ff @(posedge clk) vs_q <= vsync_in;

  assign evt = comp ? (vsync_in && !vs_q) : dsync;

  // R4: in compression an event always coincides with a fresh edge
  p_evt_edge_r4: assert property (@(posedge clk)
    (evt && comp) |-> (vsync_in && !$past(vsync_in)));
endmodule

// File: rtl/fc_fsm.sv
module fc_fsm
  import frame_ctrl_pkg::*;
(
  input  logic clk,
  input  logic irst,
  input  logic go,
  input  logic start,
  input  logic seq,
  input  logic evt,
  input  logic eof,
  output logic fbusy,
  output logic go_clr
);
  fc_state_e st, nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:  if (go && start) nxt = ST_ARMED;
      ST_ARMED: begin
        if (!go || !start) nxt = ST_IDLE;
        else if (evt)      nxt = ST_BUSY;
      end
      ST_BUSY:  if (eof) nxt = ST_DONE;
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (irst) begin
      st     <= ST_IDLE;
      fbusy  <= 1'b0;
      go_clr <= 1'b0;
    end else begin
      st     <= nxt;
      fbusy  <= (nxt == ST_BUSY);
      go_clr <= (nxt == ST_DONE) && !seq;
    end
  end

  // R3: losing GO or START while armed disarms
  p_disarm_r3: assert property (@(posedge clk) disable iff (irst)
    (st == ST_ARMED && (!go || !start)) |=> (st == ST_IDLE));
  // R7: DONE never lasts more than one cycle
  p_done_short_r7: assert property (@(posedge clk) disable iff (irst)
    (st == ST_DONE) |=> (st == ST_IDLE));
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl #(
  parameter int MIN_RST = 8,
  parameter int STRETCH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic start,
  input  logic comp,
  input  logic seq,
  input  logic vsync_in,
  input  logic dsync,
  input  logic eof,
  output logic fbusy,
  output logic go_clr
);
  logic irst;
  logic evt;

  fc_rst_stretch #(.MIN_RST(MIN_RST), .STRETCH(STRETCH)) u_rst (
    .clk(clk), .rst(rst), .irst(irst)
  );

  fc_event_sel u_evt (
    .clk(clk), .comp(comp), .vsync_in(vsync_in), .dsync(dsync), .evt(evt)
  );

  fc_fsm u_fsm (
    .clk(clk), .irst(irst), .go(go), .start(start), .seq(seq),
    .evt(evt), .eof(eof), .fbusy(fbusy), .go_clr(go_clr)
  );

  p_rst_quiet_r1: assert property (@(posedge clk)
    rst |=> (!fbusy && !go_clr));
  p_stretch_quiet_r2: assert property (@(posedge clk)
    irst |=> !fbusy);
  p_start_armed_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(fbusy) |-> ($past(go) && $past(start)));
  p_comp_edge_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(fbusy) && $past(comp)) |-> ($past(vsync_in) && !$past(vsync_in, 2)));
  p_exp_dsync_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(fbusy) && !$past(comp)) |-> $past(dsync));
  p_hold_busy_r6: assert property (@(posedge clk) disable iff (irst)
    (fbusy && !eof) |=> fbusy);
  p_end_on_eof_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(fbusy) |-> $past(eof));
  p_clr_single_r7: assert property (@(posedge clk) disable iff (rst)
    ($fell(fbusy) && !$past(seq)) |-> go_clr);
  p_clr_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    go_clr |=> !go_clr);
  p_no_clr_seq_r8: assert property (@(posedge clk) disable iff (rst)
    go_clr |-> !$past(seq));
endmodule

// File: tb/frame_ctrl_tb.sv
module frame_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go = 0, start = 0, comp = 0, seq = 0, vsync_in = 0, dsync = 0, eof = 0;
  logic fbusy, go_clr;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  frame_ctrl u_dut (
    .clk(clk), .rst(rst), .go(go), .start(start), .comp(comp), .seq(seq),
    .vsync_in(vsync_in), .dsync(dsync), .eof(eof),
    .fbusy(fbusy), .go_clr(go_clr)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive the start event of the selected direction
  task automatic fire(logic c);
    if (c) vsync_in = 1'b1; else dsync = 1'b1;
    step();
    dsync = 1'b0;
  endtask

  // Drive the start event of the other direction (must be ignored)
  task automatic fire_wrong(logic c);
    if (c) dsync = 1'b1; else vsync_in = 1'b1;
    step();
    dsync = 1'b0;
    vsync_in = 1'b0;
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (10) step();
    chk("R1 fbusy", fbusy, 1'b0);
    chk("R1 go_clr", go_clr, 1'b0);

    // Release with everything ready: expansion, dsync held high
    go = 1; start = 1; comp = 0; seq = 0; dsync = 1; rst = 0;
    step(); chk("R2 edge1", fbusy, 1'b0);
    step(); chk("R2 edge2", fbusy, 1'b0);
    step(); chk("R2 arm edge", fbusy, 1'b0);
    step(); chk("R2 first start", fbusy, 1'b1);
    dsync = 0; eof = 1;
    step(); chk("R6 end", fbusy, 1'b0); chk("R7 clr", go_clr, 1'b1);
    eof = 0; go = 0;
    step(); chk("R7 clr one cycle", go_clr, 1'b0);

    for (int c = 0; c < 2; c++) begin
      for (int s = 0; s < 2; s++) begin
        comp = logic'(c); seq = logic'(s);
        vsync_in = 0; dsync = 0; step(); step();

        // START dropped while armed
        go = 1; start = 1; step();
        start = 0; step();
        start = 1; fire(comp);
        chk("R3 start dropped", fbusy, 1'b0);
        vsync_in = 0; go = 0; start = 0; step(); step();

        // GO cleared while armed
        go = 1; start = 1; step();
        go = 0; fire(comp);
        chk("R3 go cleared", fbusy, 1'b0);
        vsync_in = 0; step(); step();

        // Arm properly; the other direction's event is ignored
        go = 1; start = 1; step();
        fire_wrong(comp);
        chk(comp ? "R4 dsync ignored" : "R5 vsync ignored", fbusy, 1'b0);
        fire(comp);
        chk(comp ? "R4 start" : "R5 start", fbusy, 1'b1);
        if (!seq) go = 0;
        for (int k = 0; k < 4; k++) begin
          step(); chk("R6 held", fbusy, 1'b1);
        end
        eof = 1; step();
        chk("R6 end", fbusy, 1'b0);
        chk(seq ? "R8 no clr" : "R7 clr", go_clr, !seq);
        eof = 0; step();
        chk("R7 clr gone", go_clr, 1'b0);

        if (seq) begin
          // vsync_in still high (compression) - must not restart
          step(); step();
          chk(comp ? "R9 held level" : "R8 idle w/o event", fbusy, 1'b0);
          vsync_in = 0; step();
          fire(comp);
          chk("R8 auto restart", fbusy, 1'b1);
          eof = 1; step(); eof = 0;
          chk("R8 second end", fbusy, 1'b0);
          chk("R8 no clr second", go_clr, 1'b0);
          go = 0; start = 0;
        end else begin
          vsync_in = 0; step(); step();
          fire(comp);
          chk("R7 idle after clear", fbusy, 1'b0);
        end
        vsync_in = 0; dsync = 0; step(); step();
      end
    end

    // Reset during a period
    comp = 0; seq = 0; go = 1; start = 1; step();
    fire(1'b0);
    chk("R5 pre-reset start", fbusy, 1'b1);
    rst = 1; repeat (9) step();
    chk("R1 reset mid period", fbusy, 1'b0);
    rst = 0; go = 0; start = 0; step(); step(); step();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule